// File: doc/BRIEF.md
# Pending Packet Counter with Interrupt Flag

This block keeps an 8-bit tally of received packets that software has not yet consumed. Each time the receive path reports a packet that has been taken in whole, the tally goes up by one. Each one-cycle decrement command from software takes it down by one. A pending flag follows the tally and serves as the interrupt request for "packets waiting".

The tally saturates at both ends. A decrement at zero does nothing. Once the tally sits at its maximum, a reject signal tells the receive path to refuse every new packet, even if buffer space remains. Each refused packet also produces a one-cycle error strobe.

The receive-enable input gates packet completions. While it is low, completion strobes are ignored entirely, and software decrements still take effect.

Top module: `pkt_pend_counter`

## Requirements
- R1: During and straight after reset, count_o is 0, and pending_o, reject_o and err_o are all 0.
- R2: A completion (pkt_done_i=1, rx_en_i=1) sampled while count_o is below 255, with no valid decrement, makes count_o one higher after that clock edge.
- R3: A decrement (dec_i=1) sampled while count_o is above 0, with no accepted completion, makes count_o one lower after that clock edge.
- R4: A decrement sampled while count_o is 0 leaves count_o at 0; it never wraps to 255.
- R5: An accepted completion and a valid decrement sampled at the same edge leave count_o unchanged.
- R6: pending_o goes to 1 on every increment and stays 1 while count_o is nonzero. It drops to 0 when a decrement brings count_o to 0, so pending_o is 1 exactly when count_o is nonzero.
- R7: reject_o is 1 exactly when count_o equals 255, in the same cycle, with no register delay.
- R8: A completion with rx_en_i=1 sampled while count_o is 255 is refused. It does not raise the count, and err_o is 1 for the one cycle after that edge, once per refused packet.
- R9: While rx_en_i is 0, pkt_done_i has no effect. The count is not raised and err_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_done_i | input | 1 | One-cycle strobe: a packet was received in whole |
| rx_en_i | input | 1 | Receive enable; gates pkt_done_i |
| dec_i | input | 1 | One-cycle software command: one packet consumed |
| count_o | output | 8 | Packets waiting |
| pending_o | output | 1 | Packets-waiting interrupt flag |
| reject_o | output | 1 | Count is saturated; new packets must be refused |
| err_o | output | 1 | One-cycle strobe per refused packet |

## Verification
Two functions can land in the same cycle: a packet completion and a software decrement. They can meet at the empty end, the full end, or anywhere between. Directed steps drive both strobes together at count 0, in mid range and at 255. Long random stretches with phase-dependent strobe rates make the collisions happen repeatedly across the whole range. At every cycle a bench model judges the count, the flag, the reject level and the error strobe: an accepted completion cancels a valid decrement, a decrement at zero is void, and a refusal at 255 still lets the decrement lower the count while pulsing the error.

// File: rtl/pkt_pend_pkg.sv
package pkt_pend_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_UP   = 2'd1,
      CNT_DOWN = 2'd2
   } cnt_op_e;
endpackage

// File: rtl/pkt_pend_ctl.sv
// Arbitration between completion and decrement; detects the saturated ends.
module pkt_pend_ctl
   import pkt_pend_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             done,
   input  logic             en,
   input  logic             dec,
   input  logic [CNT_W-1:0] count,
   output cnt_op_e          op,
   output logic             rej_evt,
   output logic             full,
   output logic             at_one
);
   localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   logic accept;
   logic take;

   always_comb begin
      full    = (count == MAX_C);
      at_one  = (count == ONE_C);
      accept  = done && en && !full;
      rej_evt = done && en && full;
      take    = dec && (count != '0);
      unique case ({accept, take})
         2'b10:   op = CNT_UP;
         2'b01:   op = CNT_DOWN;
         default: op = CNT_HOLD;
      endcase
   end
endmodule

// File: rtl/pkt_pend_cnt.sv
// Count register; the arbiter already guarantees no wrap at either end.
module pkt_pend_cnt
   import pkt_pend_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_op_e          op,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         unique case (op)
            CNT_UP:   count <= count + 1'b1;
            CNT_DOWN: count <= count - 1'b1;
            default:  count <= count;
         endcase
      end
   end
endmodule

// File: rtl/pkt_pend_flag.sv
// Pending flag: set by any increment, cleared by the decrement that empties.
module pkt_pend_flag
   import pkt_pend_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  cnt_op_e op,
   input  logic    at_one,
   output logic    pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (op == CNT_UP) begin
         pend <= 1'b1;
      end else if (op == CNT_DOWN && at_one) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/pkt_pend_err.sv
// Error strobe: registered pulse (default) or same-cycle combinational pulse.
module pkt_pend_err #(
   parameter bit ERR_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rej_evt,
   output logic err
);
   generate
      if (ERR_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err <= 1'b0;
            else        err <= rej_evt;
         end
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign err = rej_evt;
      end
   endgenerate
endmodule

// File: rtl/pkt_pend_counter.sv
module pkt_pend_counter
   import pkt_pend_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit ERR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_done_i,
   input  logic             rx_en_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] count_o,
   output logic             pending_o,
   output logic             reject_o,
   output logic             err_o
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("pkt_pend_counter: CNT_W must lie in 2..16");
      end
   endgenerate

   cnt_op_e op;
   logic    rej_evt;
   logic    full;
   logic    at_one;

   pkt_pend_ctl #(.CNT_W(CNT_W)) u_ctl (
      .done   (pkt_done_i),
      .en     (rx_en_i),
      .dec    (dec_i),
      .count  (count_o),
      .op     (op),
      .rej_evt(rej_evt),
      .full   (full),
      .at_one (at_one)
   );

   pkt_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (op),
      .count(count_o)
   );

   pkt_pend_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .at_one(at_one),
      .pend  (pending_o)
   );

   pkt_pend_err #(.ERR_REG(ERR_REG)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .rej_evt(rej_evt),
      .err    (err_o)
   );

   assign reject_o = full;
endmodule

// File: rtl/pkt_pend_counter_chk.sv
module pkt_pend_counter_chk #(
   parameter int CNT_W   = 8,
   parameter bit ERR_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pkt_done_i,
   input logic             rx_en_i,
   input logic             dec_i,
   input logic [CNT_W-1:0] count_o,
   input logic             pending_o,
   input logic             reject_o,
   input logic             err_o
);
   localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R1: assert (count_o == '0 && !pending_o && !err_o)
            else $error("R1: outputs not cleared in reset");
      end
   end

   assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done_i && rx_en_i && count_o != MAX_C && !dec_i)
      |=> count_o == $past(count_o) + 1'b1);

   assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && count_o != '0 && !(pkt_done_i && rx_en_i && count_o != MAX_C))
      |=> count_o == $past(count_o) - 1'b1);

   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && count_o == '0 && !(pkt_done_i && rx_en_i))
      |=> count_o == '0);

   assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && count_o != '0 && pkt_done_i && rx_en_i && count_o != MAX_C)
      |=> $stable(count_o));

   assert_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o == (count_o != '0));

   assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reject_o == (count_o == MAX_C));

   assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done_i && !rx_en_i && !dec_i) |=> $stable(count_o) && !err_o);

   generate
      if (ERR_REG) begin : g_err_reg
         assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pkt_done_i && rx_en_i && reject_o) |=> err_o);
         assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            err_o |-> $past(pkt_done_i && rx_en_i && reject_o));
      end else begin : g_err_comb
         assert_err_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
            err_o == (pkt_done_i && rx_en_i && reject_o));
      end
   endgenerate
endmodule

bind pkt_pend_counter pkt_pend_counter_chk #(.CNT_W(CNT_W), .ERR_REG(ERR_REG)) u_chk (.*);

// File: tb/test_pkt_pend_counter.sv
`timescale 1ns/1ps
module test_pkt_pend_counter;
   localparam int MAXV = 255;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_done_i = 1'b0;
   logic       rx_en_i = 1'b0;
   logic       dec_i = 1'b0;
   logic [7:0] count_o;
   logic       pending_o;
   logic       reject_o;
   logic       err_o;

   int n_cmp = 0;
   int n_bad = 0;
   int m = 0;
   bit exp_err = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pkt_pend_counter i_pkt_pend_counter (
      .clk(clk), .rst_n(rst_n), .pkt_done_i(pkt_done_i), .rx_en_i(rx_en_i),
      .dec_i(dec_i), .count_o(count_o), .pending_o(pending_o),
      .reject_o(reject_o), .err_o(err_o)
   );

   function automatic int next_count(int cur, bit d, bit e, bit c);
      bit inc = d && e && (cur != MAXV);
      bit dv  = c && (cur != 0);
      if (inc && !dv) return cur + 1;
      if (dv && !inc) return cur - 1;
      return cur;
   endfunction

   task automatic cmp(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      cmp({tag, " count"}, int'(count_o), m);
      cmp("R6 pending", int'(pending_o), int'(m != 0));
      cmp("R7 reject", int'(reject_o), int'(m == MAXV));
      cmp("R8 err", int'(err_o), int'(exp_err));
   endtask

   task automatic step(bit d, bit e, bit c, string tag);
      @(negedge clk);
      pkt_done_i = d; rx_en_i = e; dec_i = c;
      exp_err = d && e && (m == MAXV);
      m = next_count(m, d, e, c);
      @(posedge clk);
      #1;
      check_all(tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check_all("R1");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_all("R1");

      // R4: decrement at empty, alone and together with a completion
      step(0, 1, 1, "R4");
      step(1, 1, 1, "R4");            // decrement void, completion wins -> 1
      step(0, 1, 1, "R3");            // back to 0, flag clears (R6)
      // R9: completion while receive disabled
      step(1, 0, 0, "R9");
      step(1, 1, 0, "R2");
      step(1, 1, 1, "R5");
      // fill to saturation
      while (m < MAXV) step(1, 1, 0, "R2");
      // R8: refusals at full, consecutive, then with rx disabled (R9)
      step(1, 1, 0, "R8");
      step(1, 1, 0, "R8");
      step(0, 1, 0, "R8");
      step(1, 0, 0, "R9");
      // refusal while decrementing: count drops, error still pulses
      step(1, 1, 1, "R8");
      step(1, 1, 1, "R5");
      // drain to empty
      while (m > 0) step(0, 1, 1, "R3");
      step(0, 0, 1, "R4");

      // random phases: filling bias then draining bias
      for (int i = 0; i < 6000; i++) begin
         bit fill = ((i / 700) % 2) == 0;
         bit d = ($urandom % 100) < (fill ? 92 : 25);
         bit e = ($urandom % 100) < 90;
         bit c = ($urandom % 100) < (fill ? 15 : 75);
         step(d, e, c, "R5");
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule